// File: doc/BRIEF.md
# Split Dual-Mode Timer Pair

This block holds two up-counters of `DW` bits each, a low half and a high half, behind a small word-addressed register port. A global control register picks how the pair is used. In the split mode the halves run as two unrelated timers, each with its own period and its own interrupt pulse. In the wide mode they form one counter of twice the width, with the low half's interrupt as its only output. Each half has a release bit; while that bit is clear the half is held at zero.

Counting advances only on cycles where the `tick` clock-enable is high. Each half has a two-bit run field that chooses between stopped, single-shot and continuous operation. When a half's count equals its period on a tick, the half restarts from zero and raises its interrupt for one cycle. In single-shot operation the run field also drops back to stopped. Software loads counters and periods directly. The intended sequence is to stop the half, clear its counter, set the period and then start it.

Top module: `split_timer_pair`

## Requirements
- R1: After reset, every register reads zero except the identification word at byte offset 0x00, which reads the `ID_VALUE` parameter. Both interrupt outputs are low.
- R2: Register map by byte offset:
  - 0x10 is the low count and 0x14 the high count.
  - 0x18 is the low period and 0x1C the high period.
  - 0x20 is the run control: bits 7:6 are the low run field, bits 23:22 the high run field, and all other bits read 0.
  - 0x24 is the global control, bits 3:0.
  - Any other offset, and any address with bits 1:0 not zero, reads 0 and ignores writes.
- R3: Global control bit 0 releases the low half and bit 1 the high half. While a half's bit is 0, its count is held at zero, counter writes to it are ignored and it does not count.
- R4: In the split mode (global bits 3:2 = 1), run codes 2 and 3 both mean continuous. On a tick where a half's count equals its period, the count goes to zero. Otherwise the tick adds one. Each match produces a one-cycle high on that half's interrupt, in the cycle right after the clock edge that takes the match.
- R5: Run code 1 means single-shot. On its match the half restarts at zero, pulses its interrupt, and its run field reads back 0. After that it no longer counts.
- R6: On cycles with `tick` low, no counter changes except through a register write, and no interrupt follows such a cycle.
- R7: In the wide mode (global bits 3:2 = 0), both halves must be released and the low run field governs. The high run field has no effect. The count is {high, low}, and a wrap of the low half adds one to the high half. The match compares against {high period, low period} and pulses only `irqLo`. `irqHi` stays low.
- R8: In the split continuous mode with a period of all ones, a half runs freely through all ones to zero and pulses its interrupt at each wrap.
- R9: Global mode codes 2 and 3 stop both counters. They still accept counter writes.
- R10: A counter write in the same cycle as a counting tick wins: the written value is what the count holds afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | AW | Byte address of the register access |
| wrData | input | DW | Write data |
| wrEn | input | 1 | Write strobe, one write per high cycle |
| rdData | output | DW | Read data for `addr`, combinational |
| tick | input | 1 | Count enable; counters advance only when high |
| irqLo | output | 1 | Low-half (or wide-mode) match pulse |
| irqHi | output | 1 | High-half match pulse (split mode only) |

## Verification
The assertions assume only that `tick` and the register strobes are sampled on the clock, that reset is held for at least one edge, and that a write lasts a single cycle. They place no limit on how often ticks arrive or on when software writes. The stimulus respects this by driving every input on the falling edge and holding `wrEn` for exactly one cycle per access. It deliberately mixes writes with ticking cycles, including a counter load on a counting tick, so that write precedence is exercised. Tick patterns alternate and stall so that gated cycles are covered. Periods are chosen small, or counters are preloaded near all ones, so that wraps, carries and matches fall within a few dozen cycles.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;

  typedef enum logic [1:0] {
    RUN_OFF   = 2'd0,
    RUN_ONCE  = 2'd1,
    RUN_CONT  = 2'd2,
    RUN_CONT3 = 2'd3
  } runMode_e;

  // word indices (byte offset / 4) of the register file
  localparam int IDX_ID     = 0;
  localparam int IDX_CNT_LO = 4;
  localparam int IDX_CNT_HI = 5;
  localparam int IDX_PRD_LO = 6;
  localparam int IDX_PRD_HI = 7;
  localparam int IDX_RUN    = 8;
  localparam int IDX_GLOBAL = 9;

  // strobes from the control to the datapath
  typedef struct packed {
    logic relLo;
    logic relHi;
    logic dual;
    logic mode64;
    logic stepLo;
    logic stepHi;
    logic wrCntLo;
    logic wrCntHi;
    logic wrPrdLo;
    logic wrPrdHi;
  } dpCtl_t;

endpackage

// File: rtl/stp_datapath.sv
module stp_datapath
  import split_timer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] cntLo,
  output logic [DW-1:0] cntHi,
  output logic [DW-1:0] prdLo,
  output logic [DW-1:0] prdHi,
  output logic          eventLo,
  output logic          eventHi,
  output logic          irqLo,
  output logic          irqHi
);

  localparam int WW = 2 * DW;

  logic [WW-1:0] wide;
  logic [WW-1:0] wideNext;
  logic          hitLo;
  logic          hitHi;
  logic [DW-1:0] hiNextSplit;

  always_comb begin
    wide        = {cntHi, cntLo};
    hitLo       = ctl.dual ? (cntLo == prdLo) : (wide == {prdHi, prdLo});
    hitHi       = (cntHi == prdHi);
    wideNext    = hitLo ? '0 : wide + WW'(1);
    hiNextSplit = hitHi ? '0 : cntHi + DW'(1);
    eventLo     = ctl.stepLo && hitLo;
    eventHi     = ctl.stepHi && hitHi;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntLo <= '0;
      cntHi <= '0;
      prdLo <= '0;
      prdHi <= '0;
      irqLo <= 1'b0;
      irqHi <= 1'b0;
    end else begin
      irqLo <= eventLo;
      irqHi <= eventHi;
      if (ctl.wrPrdLo) prdLo <= wrData;
      if (ctl.wrPrdHi) prdHi <= wrData;

      if (!ctl.relLo)        cntLo <= '0;
      else if (ctl.wrCntLo)  cntLo <= wrData;
      else if (ctl.stepLo)   cntLo <= wideNext[DW-1:0];

      if (!ctl.relHi)                     cntHi <= '0;
      else if (ctl.wrCntHi)               cntHi <= wrData;
      else if (ctl.stepHi)                cntHi <= hiNextSplit;
      else if (ctl.mode64 && ctl.stepLo)  cntHi <= wideNext[WW-1:DW];
    end
  end

  // R3: an unreleased half sits at zero one cycle later
  a_r3_hold_zero: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.relLo |=> cntLo == '0);

  // R4: a counted match without a competing write restarts from zero
  a_r4_match_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (eventLo && ctl.relLo && !ctl.wrCntLo) |=> cntLo == '0);

  // R6: an interrupt only ever follows a ticking cycle
  a_r6_irq_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    irqLo |-> $past(ctl.stepLo));

  // R7: wide mode held over two cycles never raises the high interrupt
  a_r7_no_high_irq: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mode64 && $past(ctl.mode64)) |-> !irqHi);

  // R9: idle modes leave an unwritten counter untouched
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.dual && !ctl.mode64 && ctl.relLo && !ctl.wrCntLo) |=> $stable(cntLo));

endmodule

// File: rtl/stp_ctrl.sv
module stp_ctrl
  import split_timer_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          AW       = 6,
  parameter logic [31:0] ID_VALUE = 32'h7A11_0001
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addr,
  input  logic          wrEn,
  input  logic [1:0]    runLoWr,
  input  logic [1:0]    runHiWr,
  input  logic [3:0]    globalWr,
  input  logic          tick,
  input  logic          eventLo,
  input  logic          eventHi,
  input  logic [DW-1:0] cntLo,
  input  logic [DW-1:0] cntHi,
  input  logic [DW-1:0] prdLo,
  input  logic [DW-1:0] prdHi,
  output dpCtl_t        ctl,
  output logic [DW-1:0] rdData
);

  localparam int IW = AW - 2;

  runMode_e      runLo;
  runMode_e      runHi;
  logic [1:0]    relBits;
  logic [1:0]    modeSel;
  logic [IW-1:0] wordIdx;
  logic          aligned;
  logic          wrRun;
  logic          wrGlobal;
  logic [DW-1:0] runWord;

  always_comb begin
    wordIdx  = addr[AW-1:2];
    aligned  = (addr[1:0] == 2'b00);
    wrRun    = wrEn && aligned && (wordIdx == IW'(IDX_RUN));
    wrGlobal = wrEn && aligned && (wordIdx == IW'(IDX_GLOBAL));

    ctl         = '0;
    ctl.relLo   = relBits[0];
    ctl.relHi   = relBits[1];
    ctl.dual    = (modeSel == 2'd1);
    ctl.mode64  = (modeSel == 2'd0);
    ctl.stepLo  = tick && relBits[0] && (runLo != RUN_OFF)
                  && (ctl.dual || (ctl.mode64 && relBits[1]));
    ctl.stepHi  = tick && relBits[1] && (runHi != RUN_OFF) && ctl.dual;
    ctl.wrCntLo = wrEn && aligned && (wordIdx == IW'(IDX_CNT_LO));
    ctl.wrCntHi = wrEn && aligned && (wordIdx == IW'(IDX_CNT_HI));
    ctl.wrPrdLo = wrEn && aligned && (wordIdx == IW'(IDX_PRD_LO));
    ctl.wrPrdHi = wrEn && aligned && (wordIdx == IW'(IDX_PRD_HI));

    runWord        = '0;
    runWord[7:6]   = runLo;
    runWord[23:22] = runHi;

    rdData = '0;
    if (aligned) begin
      case (wordIdx)
        IW'(IDX_ID):     rdData = DW'(ID_VALUE);
        IW'(IDX_CNT_LO): rdData = cntLo;
        IW'(IDX_CNT_HI): rdData = cntHi;
        IW'(IDX_PRD_LO): rdData = prdLo;
        IW'(IDX_PRD_HI): rdData = prdHi;
        IW'(IDX_RUN):    rdData = runWord;
        IW'(IDX_GLOBAL): rdData = DW'({modeSel, relBits});
        default:         rdData = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runLo   <= RUN_OFF;
      runHi   <= RUN_OFF;
      relBits <= 2'b00;
      modeSel <= 2'b00;
    end else begin
      if (wrRun) begin
        runLo <= runMode_e'(runLoWr);
        runHi <= runMode_e'(runHiWr);
      end else begin
        if (eventLo && runLo == RUN_ONCE) runLo <= RUN_OFF;
        if (eventHi && runHi == RUN_ONCE) runHi <= RUN_OFF;
      end
      if (wrGlobal) begin
        relBits <= globalWr[1:0];
        modeSel <= globalWr[3:2];
      end
    end
  end

  // R5: a single-shot match drops the run field unless software rewrites it
  a_r5_oneshot_stops: assert property (@(posedge clk) disable iff (!rstN)
    (eventHi && runHi == RUN_ONCE && !wrRun) |=> runHi == RUN_OFF);

  // R6: without a tick neither half is stepped
  a_r6_no_step_idle: assert property (@(posedge clk) disable iff (!rstN)
    !tick |-> !(ctl.stepLo || ctl.stepHi));

endmodule

// File: rtl/split_timer_pair.sv
module split_timer_pair
  import split_timer_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          AW       = 6,
  parameter logic [31:0] ID_VALUE = 32'h7A11_0001
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  input  logic          wrEn,
  output logic [DW-1:0] rdData,
  input  logic          tick,
  output logic          irqLo,
  output logic          irqHi
);

  dpCtl_t        ctl;
  logic [DW-1:0] cntLo;
  logic [DW-1:0] cntHi;
  logic [DW-1:0] prdLo;
  logic [DW-1:0] prdHi;
  logic          eventLo;
  logic          eventHi;

  stp_ctrl #(.DW(DW), .AW(AW), .ID_VALUE(ID_VALUE)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .wrEn     (wrEn),
    .runLoWr  (wrData[7:6]),
    .runHiWr  (wrData[23:22]),
    .globalWr (wrData[3:0]),
    .tick     (tick),
    .eventLo  (eventLo),
    .eventHi  (eventHi),
    .cntLo    (cntLo),
    .cntHi    (cntHi),
    .prdLo    (prdLo),
    .prdHi    (prdHi),
    .ctl      (ctl),
    .rdData   (rdData)
  );

  stp_datapath #(.DW(DW)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .wrData  (wrData),
    .cntLo   (cntLo),
    .cntHi   (cntHi),
    .prdLo   (prdLo),
    .prdHi   (prdHi),
    .eventLo (eventLo),
    .eventHi (eventHi),
    .irqLo   (irqLo),
    .irqHi   (irqHi)
  );

endmodule

// File: tb/sim_split_timer_pair.sv
module sim_split_timer_pair;

  localparam logic [31:0] ID = 32'h7A11_0001;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic        wrEn = 1'b0;
  logic [31:0] rdData;
  logic        tick = 1'b0;
  logic        irqLo;
  logic        irqHi;

  int total = 0;
  int bad = 0;
  string req = "R1";

  // behavioural reference state
  bit [31:0] mLo, mHi, mPLo, mPHi;
  bit [1:0]  mRunLo, mRunHi;
  bit [3:0]  mGlob;
  bit        mIrqLo, mIrqHi;

  always #10 clk = ~clk;

  split_timer_pair u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdData(rdData), .tick(tick), .irqLo(irqLo), .irqHi(irqHi)
  );

  function automatic bit [31:0] expRead(bit [5:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a)
      6'h00: return ID;
      6'h10: return mLo;
      6'h14: return mHi;
      6'h18: return mPLo;
      6'h1C: return mPHi;
      6'h20: return {8'h0, mRunHi, 14'h0, mRunLo, 6'h0};
      6'h24: return {28'h0, mGlob};
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelStep();
    bit dual, wide, relL, relH, stepL, stepH, hitL, hitH, evL, evH;
    bit [63:0] w;
    bit [31:0] nLo, nHi;
    relL = mGlob[0];
    relH = mGlob[1];
    dual = (mGlob[3:2] == 2'd1);
    wide = (mGlob[3:2] == 2'd0);
    stepL = tick && relL && (mRunLo != 0) && (dual || (wide && relH));
    stepH = tick && relH && (mRunHi != 0) && dual;
    hitL = dual ? (mLo == mPLo) : ({mHi, mLo} == {mPHi, mPLo});
    hitH = (mHi == mPHi);
    evL = stepL && hitL;
    evH = stepH && hitH;
    nLo = mLo;
    nHi = mHi;
    if (wide && stepL) begin
      w = hitL ? 64'd0 : {mHi, mLo} + 64'd1;
      nLo = w[31:0];
      nHi = w[63:32];
    end else begin
      if (stepL) nLo = hitL ? 32'd0 : mLo + 32'd1;
      if (stepH) nHi = hitH ? 32'd0 : mHi + 32'd1;
    end
    if (wrEn && addr == 6'h10) nLo = wrData;
    if (wrEn && addr == 6'h14) nHi = wrData;
    if (!relL) nLo = 0;
    if (!relH) nHi = 0;
    if (wrEn && addr == 6'h18) mPLo = wrData;
    if (wrEn && addr == 6'h1C) mPHi = wrData;
    if (wrEn && addr == 6'h20) begin
      mRunLo = wrData[7:6];
      mRunHi = wrData[23:22];
    end else begin
      if (evL && mRunLo == 2'd1) mRunLo = 0;
      if (evH && mRunHi == 2'd1) mRunHi = 0;
    end
    if (wrEn && addr == 6'h24) mGlob = wrData[3:0];
    mLo = nLo;
    mHi = nHi;
    mIrqLo = evL;
    mIrqHi = evH;
  endtask

  task automatic check(string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check("irqLo", {31'h0, irqLo}, {31'h0, mIrqLo});
    check("irqHi", {31'h0, irqHi}, {31'h0, mIrqHi});
    check("rdData", rdData, expRead(addr));
  endtask

  task automatic wr(bit [5:0] a, bit [31:0] d);
    addr = a;
    wrData = d;
    wrEn = 1'b1;
    cyc();
    wrEn = 1'b0;
  endtask

  task automatic run(bit [5:0] a, int n, bit t);
    addr = a;
    tick = t;
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL %s watchdog expired got=hung exp=done", req);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of every register and both interrupts
    req = "R1";
    foreach (addr[i]) ;
    for (int a = 0; a < 48; a += 4) begin
      addr = 6'(a);
      #1 check("reset read", rdData, expRead(6'(a)));
    end
    check("reset irqLo", {31'h0, irqLo}, 32'h0);

    // R2: map, unmapped and misaligned accesses
    req = "R2";
    wr(6'h18, 32'h1234_5678);
    wr(6'h1C, 32'h0BAD_F00D);
    wr(6'h28, 32'hFFFF_FFFF);
    wr(6'h19, 32'hFFFF_FFFF);
    wr(6'h20, 32'hFFFF_FFFF);
    run(6'h20, 1, 0);
    wr(6'h20, 32'h0);
    run(6'h18, 1, 0);
    run(6'h1C, 1, 0);
    run(6'h28, 1, 0);

    // R3: halves held in reset ignore counter writes and ticks
    req = "R3";
    wr(6'h24, 32'h4);
    wr(6'h18, 32'd2);
    wr(6'h20, 32'h0040_0080);
    wr(6'h10, 32'd5);
    wr(6'h14, 32'd7);
    run(6'h10, 5, 1);
    run(6'h14, 1, 1);

    // R6: gated ticks in the split continuous mode
    req = "R6";
    tick = 0;
    wr(6'h20, 32'h0);
    wr(6'h24, 32'h7);
    wr(6'h10, 32'h0);
    wr(6'h18, 32'd3);
    wr(6'h20, 32'h80);
    for (int i = 0; i < 16; i++) run(6'h10, 1, i[0]);
    run(6'h10, 6, 0);

    // R4: continuous operation with code 2, then code 3
    req = "R4";
    run(6'h10, 10, 1);
    wr(6'h20, 32'hC0);
    run(6'h10, 10, 1);

    // R10: counter write on a ticking cycle wins
    req = "R10";
    wr(6'h18, 32'h200);
    wr(6'h10, 32'h100);
    run(6'h10, 3, 1);

    // R5: single-shot on the high half
    req = "R5";
    tick = 0;
    wr(6'h20, 32'h0);
    wr(6'h14, 32'h0);
    wr(6'h1C, 32'd2);
    wr(6'h20, 32'h0040_0000);
    run(6'h20, 5, 1);
    run(6'h14, 4, 1);

    // R9: idle global modes
    req = "R9";
    wr(6'h20, 32'h0040_0080);
    wr(6'h24, 32'hB);
    wr(6'h10, 32'd1);
    run(6'h10, 4, 1);
    wr(6'h24, 32'hF);
    run(6'h14, 4, 1);

    // R7: wide mode with a carry from low into high
    req = "R7";
    tick = 0;
    wr(6'h24, 32'h3);
    wr(6'h20, 32'h0);
    wr(6'h10, 32'hFFFF_FFFE);
    wr(6'h14, 32'h0);
    wr(6'h18, 32'h1);
    wr(6'h1C, 32'h1);
    wr(6'h20, 32'h0040_0080);
    run(6'h14, 3, 1);
    run(6'h10, 6, 1);

    // R8: free-running wrap with a period of all ones
    req = "R8";
    tick = 0;
    wr(6'h24, 32'h7);
    wr(6'h20, 32'h0);
    wr(6'h18, 32'hFFFF_FFFF);
    wr(6'h10, 32'hFFFF_FFFD);
    wr(6'h20, 32'h80);
    run(6'h10, 6, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule